// File: doc/BRIEF.md
# Jump Target and Link Unit

This block works out where a jump goes and what return address it leaves behind, for a 64-bit core whose jumps have one branch delay slot. In the decode cycle it takes the jump's program counter, the 26-bit index field of the instruction, the value of the source register and the jump kind. The four kinds are: absolute, absolute with link, register, and register with link.

The link write is produced in that same decode cycle. It names a destination register and carries the address of the instruction after the delay slot. The target is held in a register, and a pending flag is raised. The redirect is then issued in the cycle in which the delay-slot instruction retires, and not before.

Fetch, the register file itself and exception return lie outside the block.

Top module: `jump_link_unit`

## Requirements
- R1: For the absolute kinds (`jmp_kind` 2'b00 and 2'b01), the target is built from three parts. Bits 63:28 come from `cur_pc`, bits 27:2 come from `insn_index`, and bits 1:0 are zero.
- R2: An accepted absolute-with-link jump (`jmp_kind` 2'b01) raises `link_we` in its decode cycle. It sets `link_idx` to 31 and `link_value` to `cur_pc` + 8, taken modulo 2^64.
- R3: For a register jump (`jmp_kind` 2'b10), the target is `rs_value`, and `link_we` stays low. The plain absolute jump (2'b00) also writes no link.
- R4: An accepted register-with-link jump (`jmp_kind` 2'b11) targets `rs_value`. It raises `link_we` with `link_idx` = `rd_field` and `link_value` = `cur_pc` + 8.
- R5: The target is sampled in the decode cycle. Changes to `rs_value`, `cur_pc` or `insn_index` after that cycle do not alter `redirect_pc`.
- R6: `redirect_valid` is never high in the decode cycle. It rises only in a cycle where a jump is pending and `slot_retire` is high, and `redirect_pc` then shows the captured target.
- R7: Each accepted jump produces exactly one redirect. After it, `redirect_valid` stays low even if `slot_retire` stays high.
- R8: A link destination of register 0 (`rd_field` = 0 with kind 2'b11) keeps `link_we` low.
- R9: A jump presented while another jump is pending is ignored. It produces no link write and leaves the pending target unchanged.
- R10: Reset clears the pending flag, so no redirect follows reset until a new jump is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| jmp_valid | input | 1 | A jump is in decode this cycle |
| jmp_kind | input | 2 | 00 absolute, 01 absolute+link, 10 register, 11 register+link |
| cur_pc | input | 64 | Address of the jump instruction |
| insn_index | input | 26 | Instruction bits 25:0 |
| rs_value | input | 64 | Value of the register named by instruction bits 25:21 |
| rd_field | input | 5 | Instruction bits 15:11, link destination for kind 11 |
| slot_retire | input | 1 | The delay-slot instruction retires this cycle |
| link_we | output | 1 | Write the link value this cycle |
| link_idx | output | 5 | Link destination register |
| link_value | output | 64 | Return address, jump PC + 8 |
| redirect_valid | output | 1 | Fetch must move to `redirect_pc` |
| redirect_pc | output | 64 | Captured jump target |

## Verification
A pending flag that is stuck low shows up as a jump with no redirect. A flag stuck high shows up as a second redirect, or as a dropped link on the next jump, at the first cycle `slot_retire` is raised.

A captured target that is loaded at the wrong time appears at the redirect, which may be many cycles after decode. To expose this, the bench holds the delay slot open for a random number of cycles while it changes the register and PC inputs.

Link errors appear in the decode cycle itself, because the link outputs have no register.

// File: rtl/jl_pkg.sv
package jl_pkg;
  typedef enum logic [1:0] {
    JK_ABS      = 2'b00,
    JK_ABS_LINK = 2'b01,
    JK_REG      = 2'b10,
    JK_REG_LINK = 2'b11
  } jl_kind_e;

  // bit 0 of the kind selects a link write
  function automatic logic kind_links(input jl_kind_e k);
    return k[0];
  endfunction

  // bit 1 of the kind selects a register target
  function automatic logic kind_from_reg(input jl_kind_e k);
    return k[1];
  endfunction
endpackage

// File: rtl/jl_target_sel.sv
module jl_target_sel #(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 26
) (
  input  jl_pkg::jl_kind_e    kind,
  input  logic [ADDR_W-1:0]   pc,
  input  logic [IDX_W-1:0]    index,
  input  logic [ADDR_W-1:0]   reg_val,
  output logic [ADDR_W-1:0]   target
);
  localparam int REGION_LSB = IDX_W + 2;

  function automatic logic [ADDR_W-1:0] region_splice(
    input logic [ADDR_W-1:0] p, input logic [IDX_W-1:0] ix);
    logic [ADDR_W-1:0] r;
    r = '0;
    r[ADDR_W-1:REGION_LSB] = p[ADDR_W-1:REGION_LSB];
    r[REGION_LSB-1:2]      = ix;
    return r;
  endfunction

  always_comb begin
    if (jl_pkg::kind_from_reg(kind)) target = reg_val;
    else                             target = region_splice(pc, index);
  end
endmodule

// File: rtl/jl_link_gen.sv
module jl_link_gen #(
  parameter int ADDR_W   = 64,
  parameter int REG_AW   = 5,
  parameter int LINK_REG = 31,
  parameter int LINK_OFS = 8
) (
  input  logic                accept,
  input  jl_pkg::jl_kind_e    kind,
  input  logic [ADDR_W-1:0]   pc,
  input  logic [REG_AW-1:0]   rd,
  output logic                we,
  output logic [REG_AW-1:0]   idx,
  output logic [ADDR_W-1:0]   value
);
  localparam logic [REG_AW-1:0] FIXED_RA = REG_AW'(LINK_REG);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(LINK_OFS);

  function automatic logic [ADDR_W-1:0] after_slot(input logic [ADDR_W-1:0] p);
    return p + STEP;
  endfunction

  always_comb begin
    idx   = jl_pkg::kind_from_reg(kind) ? rd : FIXED_RA;
    value = after_slot(pc);
    we    = accept && jl_pkg::kind_links(kind) && (idx != '0);
  end
endmodule

// File: rtl/jl_redirect_ctrl.sv
module jl_redirect_ctrl #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] target_in,
  input  logic              slot_retire,
  output logic              pend_q,
  output logic              fire,
  output logic [ADDR_W-1:0] held_target
);
  assign fire = pend_q && slot_retire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      held_target <= '0;
    end else begin
      if (accept) begin
        pend_q      <= 1'b1;
        held_target <= target_in;
      end else if (fire) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/jump_link_unit.sv
module jump_link_unit #(
  parameter int ADDR_W   = 64,
  parameter int IDX_W    = 26,
  parameter int REG_AW   = 5,
  parameter int LINK_REG = 31,
  parameter int LINK_OFS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jmp_valid,
  input  logic [1:0]        jmp_kind,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [IDX_W-1:0]  insn_index,
  input  logic [ADDR_W-1:0] rs_value,
  input  logic [REG_AW-1:0] rd_field,
  input  logic              slot_retire,
  output logic              link_we,
  output logic [REG_AW-1:0] link_idx,
  output logic [ADDR_W-1:0] link_value,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_pc
);
  jl_pkg::jl_kind_e kind;
  logic             pend_q;
  logic             jump_accept;
  logic             redirect_fire;
  logic [ADDR_W-1:0] next_target;

  assign kind        = jl_pkg::jl_kind_e'(jmp_kind);
  assign jump_accept = jmp_valid && !pend_q;

  jl_target_sel #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_tgt (
    .kind(kind), .pc(cur_pc), .index(insn_index), .reg_val(rs_value),
    .target(next_target)
  );

  jl_link_gen #(.ADDR_W(ADDR_W), .REG_AW(REG_AW), .LINK_REG(LINK_REG),
                .LINK_OFS(LINK_OFS)) u_link (
    .accept(jump_accept), .kind(kind), .pc(cur_pc), .rd(rd_field),
    .we(link_we), .idx(link_idx), .value(link_value)
  );

  jl_redirect_ctrl #(.ADDR_W(ADDR_W)) u_redir (
    .clk(clk), .rst_n(rst_n), .accept(jump_accept), .target_in(next_target),
    .slot_retire(slot_retire), .pend_q(pend_q), .fire(redirect_fire),
    .held_target(redirect_pc)
  );

  assign redirect_valid = redirect_fire;
endmodule

// File: rtl/jl_checker.sv
module jl_checker #(
  parameter int ADDR_W = 64,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              jump_accept,
  input logic              pend_q,
  input logic              slot_retire,
  input logic              link_we,
  input logic [REG_AW-1:0] link_idx,
  input logic              redirect_valid,
  input logic [ADDR_W-1:0] redirect_pc
);
  // R6: an accepted jump leaves a pending redirect
  a_r6_pending_after_jump: assert property (@(posedge clk) disable iff (!rst_n)
    jump_accept |=> pend_q);
  // R6: a redirect needs a pending jump and a retiring slot
  a_r6_redirect_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (pend_q && slot_retire));
  // R7: only one redirect per jump
  a_r7_single_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);
  // R8: register 0 is never written
  a_r8_no_zero_link: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_idx != '0));
  // R9: no link write while a jump is pending
  a_r9_no_link_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !link_we);
  // R5: the held target does not move while waiting
  a_r5_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !redirect_valid) |=> $stable(redirect_pc));
endmodule

bind jump_link_unit jl_checker #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_jl_chk (
  .clk(clk), .rst_n(rst_n), .jump_accept(jump_accept), .pend_q(pend_q),
  .slot_retire(slot_retire), .link_we(link_we), .link_idx(link_idx),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
);

// File: tb/test_jump_link_unit.sv
module test_jump_link_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        jmp_valid = 1'b0;
  logic [1:0]  jmp_kind = 2'b00;
  logic [63:0] cur_pc = '0;
  logic [25:0] insn_index = '0;
  logic [63:0] rs_value = '0;
  logic [4:0]  rd_field = '0;
  logic        slot_retire = 1'b0;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [63:0] link_value;
  logic        redirect_valid;
  logic [63:0] redirect_pc;

  int n_chk = 0;
  int n_bad = 0;
  int seed  = 32'h5eed_1234;

  always #2 clk = ~clk;

  jump_link_unit i_jump_link_unit (.*);

  function automatic logic [63:0] exp_target(input logic [1:0] k, input logic [63:0] pc,
                                             input logic [25:0] ix, input logic [63:0] rv);
    if (k >= 2'd2) return rv;
    return (pc & ~64'h0FFF_FFFF) | ({38'd0, ix} << 2);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Full jump: decode, hold the delay slot open for `wait_n` cycles, then retire.
  task automatic run_jump(input logic [1:0] k, input logic [63:0] pc, input logic [25:0] ix,
                          input logic [63:0] rv, input logic [4:0] rd, input int wait_n);
    logic [63:0] tgt;
    logic        we_e;
    logic [4:0]  idx_e;
    tgt   = exp_target(k, pc, ix, rv);
    idx_e = (k == 2'd3) ? rd : 5'd31;
    we_e  = k[0] && (idx_e != 5'd0);
    @(negedge clk);
    jmp_valid = 1'b1; jmp_kind = k; cur_pc = pc; insn_index = ix;
    rs_value = rv; rd_field = rd; slot_retire = 1'b0;
    #1;
    chk(k == 2'd1 ? "R2" : (k == 2'd3 ? (rd == 0 ? "R8" : "R4") : "R3"),
        {63'd0, link_we}, {63'd0, we_e});
    if (we_e) begin
      chk(k == 2'd1 ? "R2" : "R4", {59'd0, link_idx}, {59'd0, idx_e});
      chk(k == 2'd1 ? "R2" : "R4", link_value, pc + 64'd8);
    end
    chk("R6", {63'd0, redirect_valid}, 64'd0);
    @(negedge clk);
    jmp_valid = 1'b0;
    for (int i = 0; i < wait_n; i++) begin
      rs_value = {$urandom(), $urandom()};
      cur_pc = {$urandom(), $urandom()};
      insn_index = 26'($urandom());
      #1;
      chk("R6", {63'd0, redirect_valid}, 64'd0);
      @(negedge clk);
    end
    slot_retire = 1'b1;
    #1;
    chk("R6", {63'd0, redirect_valid}, 64'd1);
    chk(k[1] ? "R5" : "R1", redirect_pc, tgt);
    @(negedge clk);
    #1;
    chk("R7", {63'd0, redirect_valid}, 64'd0);
    slot_retire = 1'b0;
  endtask

  initial begin
    #40000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    slot_retire = 1'b1;
    #1;
    chk("R10", {63'd0, redirect_valid}, 64'd0);
    @(negedge clk);
    slot_retire = 1'b0;

    // directed corners
    run_jump(2'd0, 64'hFFFF_FFFF_F123_4567, 26'h3FF_FFFF, 64'h0, 5'd0, 0);
    run_jump(2'd1, 64'hFFFF_FFFF_FFFF_FFFC, 26'h000_0001, 64'h0, 5'd7, 2);
    run_jump(2'd2, 64'h1000, 26'h0, 64'hDEAD_BEEF_0000_1230, 5'd9, 3);
    run_jump(2'd3, 64'h2000, 26'h0, 64'h1234_5678_9ABC_DEF0, 5'd5, 1);
    run_jump(2'd3, 64'h3000, 26'h0, 64'h4000, 5'd0, 0);

    // R9: jump while pending is ignored
    @(negedge clk);
    jmp_valid = 1'b1; jmp_kind = 2'd2; rs_value = 64'hAAAA_0000_0000_1000;
    @(negedge clk);
    jmp_kind = 2'd3; rd_field = 5'd4; rs_value = 64'hBBBB; cur_pc = 64'h500;
    #1;
    chk("R9", {63'd0, link_we}, 64'd0);
    @(negedge clk);
    jmp_valid = 1'b0; slot_retire = 1'b1;
    #1;
    chk("R9", redirect_pc, 64'hAAAA_0000_0000_1000);
    @(negedge clk);
    slot_retire = 1'b0;

    // R10: reset drops a pending jump
    jmp_valid = 1'b1; jmp_kind = 2'd0;
    @(negedge clk);
    jmp_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; slot_retire = 1'b1;
    #1;
    chk("R10", {63'd0, redirect_valid}, 64'd0);
    @(negedge clk);
    slot_retire = 1'b0;

    // random mix
    for (int n = 0; n < 60; n++)
      run_jump(2'($urandom()), {$urandom(), $urandom()}, 26'($urandom()),
               {$urandom(), $urandom()}, 5'($urandom()), int'($urandom() % 5));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule